// File: doc/BRIEF.md
# Three-Strobe Parallel Converter Sequencer

This block is the host-side controller for an external successive-approximation converter. That converter is driven by a chip-select strobe, a read/convert select line and an end-of-conversion flag, and it returns its result on a 14-bit parallel bus. Every sample takes three active-low chip-select pulses. The first pulse starts acquisition. The second pulse freezes the input and starts the conversion. The third pulse, issued only after the converter has signalled completion, places the result on the bus. The sequencer produces these strobes with minimum widths, setup times and hold times taken from nanosecond parameters and a clock-frequency parameter. It captures the word and hands it on through a valid/ready stream port.

A power-select input chooses what the converter does between samples. In the low-power mode the converter powers its reference off after each conversion. The sequencer then stretches the acquisition window by a reference wake-up interval, which is 12 ms by default. In the keep-alive mode no extra wait is added. Samples start at most once per programmed period, only while the run input is high, and only when the output stage is empty. A conversion that never reports completion is ended by a timeout: the sequencer raises a one-cycle flag and the next sample proceeds normally.

Top module: `adc_strobe_seq`

## Requirements
- R1: Each sample issues three chip-select falls in order. The select line is low (0) at the first fall and high (1) at the third fall.
- R2: At the second fall the select line equals the power-select value latched at the start of the sample: 0 for keep-alive, 1 for low-power.
- R3: The time from the first fall to the second fall is at least ACQ_NS (2 µs; 500 cycles at 250 MHz).
- R4: When low-power is selected, the time from the first fall to the second fall is at least ACQ_NS plus the WAKE_US wake-up interval.
- R5: The third fall occurs only while the completion flag is low. The word is captured no sooner than DATA_DLY_NS after that fall and is the value the bus carries at that moment.
- R6: Chip-select stays low and stays high for at least CS_LO_NS and CS_HI_NS respectively. The select line changes only while chip-select is high, at least RC_SU_NS before the next fall and at least RC_HD_NS after the previous fall.
- R7: A new first fall comes at least RELQ_NS after chip-select rises at the end of a read, and at least PERIOD_NS after the previous first fall.
- R8: If the completion flag has not gone low EOC_TMO_NS after conversion starts, the sample is abandoned. conv_timeout pulses for one cycle with chip-select high, no third fall is issued and no word is produced.
- R9: While smp_valid is high and smp_ready is low, smp_valid and smp_data hold their values and no new first fall is issued.
- R10: During and after reset, chip-select is high, the select line is low, and smp_valid and conv_timeout are low.
- R11: While run_en is low no new sample begins and chip-select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows new samples to begin |
| pwr_down_sel | input | 1 | 1 = reference off between samples, 0 = reference kept on |
| cvt_sel_n | output | 1 | Active-low chip-select to the converter |
| cvt_rdsel | output | 1 | Read/convert select line to the converter |
| cvt_done_n | input | 1 | Converter completion flag, low when the result is ready |
| cvt_bus | input | DW | Parallel result bus from the converter |
| smp_valid | output | 1 | Captured word available |
| smp_ready | input | 1 | Consumer accepts the word |
| smp_data | output | DW | Captured word |
| conv_timeout | output | 1 | One-cycle pulse when a conversion is abandoned |

## Verification
A wrong phase in the sequencer shows up at the next chip-select fall. The select line has the wrong level for that fall index, or the fall arrives before its minimum gap from the previous fall, so a defect appears within one sample of a few thousand cycles. A wrong capture moment or a lost stall shows up in the scoreboard as soon as the word is handed over: it carries the pre-settle bus value, or a word is missing or repeated. A broken timeout path shows up either as a missing flag about two thousand cycles after the second fall or as a stray third fall.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SU1, ST_F1, ST_ACQ, ST_F2, ST_CONV, ST_F3, ST_REL
    } seq_st_e;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_period_gen.sv
module seq_period_gen #(
    parameter int unsigned CW    = 16,
    parameter int unsigned C_PER = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic due
);
    localparam logic [CW-1:0] K_RELOAD = CW'(C_PER - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } per_t;

    per_t q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.cnt = K_RELOAD;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign due = (q.cnt == '0);
endmodule

// File: rtl/seq_out_hold.sv
module seq_out_hold #(
    parameter int unsigned DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] cap_data,
    output logic          o_valid,
    input  logic          o_ready,
    output logic [DW-1:0] o_data
);
    typedef struct packed {
        logic          v;
        logic [DW-1:0] dat;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (cap) begin
            d.v   = 1'b1;
            d.dat = cap_data;
        end else if (q.v && o_ready) begin
            d.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign o_valid = q.v;
    assign o_data  = q.dat;
endmodule

// File: rtl/seq_strobe_fsm.sv
module seq_strobe_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned DW        = 14,
    parameter int unsigned CW        = 16,
    parameter int unsigned SYNC      = 2,
    parameter int unsigned C_SU      = 15,
    parameter int unsigned C_LOW     = 10,
    parameter int unsigned C_ACQ_REM = 490,
    parameter int unsigned C_WAKE    = 1000,
    parameter int unsigned C_GUARD   = 15,
    parameter int unsigned C_F3      = 10,
    parameter int unsigned C_REL     = 10,
    parameter int unsigned C_TMO     = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          mode_sd,
    input  logic          done_n,
    input  logic [DW-1:0] bus,
    output logic          sel_n,
    output logic          rdsel,
    output logic          cap,
    output logic [DW-1:0] cap_data,
    output logic          tmo,
    output logic          kick,
    output seq_st_e       st
);
    localparam logic [CW-1:0] K_SU    = CW'(C_SU - 1);
    localparam logic [CW-1:0] K_LOW   = CW'(C_LOW - 1);
    localparam logic [CW-1:0] K_ACQ   = CW'(C_ACQ_REM - 1);
    localparam logic [CW-1:0] K_ACQW  = CW'(C_ACQ_REM + C_WAKE - 1);
    localparam logic [CW-1:0] K_GUARD = CW'(C_GUARD - 1);
    localparam logic [CW-1:0] K_F3    = CW'(C_F3 - 1);
    localparam logic [CW-1:0] K_REL   = CW'(C_REL - 1);
    localparam logic [CW-1:0] K_TMO   = CW'(C_TMO - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic          mode;
        logic          sel_n;
        logic          rd;
        logic          cap;
        logic [DW-1:0] word;
        logic          tmo;
        logic          kick;
    } fsm_t;

    fsm_t q, d;
    logic [SYNC-1:0] sync_q;
    logic            done_seen;
    logic            last;

    // completion flag comes from another clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], done_n};
        end
    end

    assign done_seen = ~sync_q[SYNC-1];
    assign last      = (q.cnt == '0);

    always_comb begin
        d      = q;
        d.cap  = 1'b0;
        d.tmo  = 1'b0;
        d.kick = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.sel_n = 1'b1;
                d.rd    = 1'b0;
                if (go) begin
                    d.st   = ST_SU1;
                    d.mode = mode_sd;
                    d.cnt  = K_SU;
                    d.kick = 1'b1;
                end
            end
            ST_SU1: begin
                if (last) begin
                    d.st    = ST_F1;
                    d.sel_n = 1'b0;
                    d.cnt   = K_LOW;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_F1: begin
                if (last) begin
                    d.st    = ST_ACQ;
                    d.sel_n = 1'b1;
                    d.rd    = q.mode;
                    d.cnt   = q.mode ? K_ACQW : K_ACQ;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_ACQ: begin
                if (last) begin
                    d.st    = ST_F2;
                    d.sel_n = 1'b0;
                    d.cnt   = K_LOW;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_F2: begin
                if (last) begin
                    d.st    = ST_CONV;
                    d.sel_n = 1'b1;
                    d.rd    = 1'b1;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CONV: begin
                if (done_seen && (q.cnt >= K_GUARD)) begin
                    d.st    = ST_F3;
                    d.sel_n = 1'b0;
                    d.cnt   = K_F3;
                end else if (q.cnt == K_TMO) begin
                    d.st  = ST_REL;
                    d.rd  = 1'b0;
                    d.tmo = 1'b1;
                    d.cnt = K_REL;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_F3: begin
                if (last) begin
                    d.st    = ST_REL;
                    d.sel_n = 1'b1;
                    d.rd    = 1'b0;
                    d.cap   = 1'b1;
                    d.word  = bus;
                    d.cnt   = K_REL;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_REL: begin
                if (last) begin
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.sel_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sel_n    = q.sel_n;
    assign rdsel    = q.rd;
    assign cap      = q.cap;
    assign cap_data = q.word;
    assign tmo      = q.tmo;
    assign kick     = q.kick;
    assign st       = q.st;
endmodule

// File: rtl/adc_strobe_seq.sv
module adc_strobe_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned DW          = 14,
    parameter int unsigned CLK_MHZ     = 250,
    parameter int unsigned ACQ_NS      = 2000,
    parameter int unsigned CS_HI_NS    = 40,
    parameter int unsigned CS_LO_NS    = 40,
    parameter int unsigned RC_SU_NS    = 60,
    parameter int unsigned RC_HD_NS    = 40,
    parameter int unsigned DATA_DLY_NS = 40,
    parameter int unsigned RELQ_NS     = 40,
    parameter int unsigned WAKE_US     = 12000,
    parameter int unsigned EOC_TMO_NS  = 8000,
    parameter int unsigned PERIOD_NS   = 10000,
    parameter int unsigned SYNC        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          pwr_down_sel,
    output logic          cvt_sel_n,
    output logic          cvt_rdsel,
    input  logic          cvt_done_n,
    input  logic [DW-1:0] cvt_bus,
    output logic          smp_valid,
    input  logic          smp_ready,
    output logic [DW-1:0] smp_data,
    output logic          conv_timeout
);
    localparam int unsigned C_SU0   = umax(ns_to_cyc(RC_SU_NS, CLK_MHZ), 1);
    localparam int unsigned C_CSH   = ns_to_cyc(CS_HI_NS, CLK_MHZ);
    localparam int unsigned C_CSL   = ns_to_cyc(CS_LO_NS, CLK_MHZ);
    localparam int unsigned C_HD    = ns_to_cyc(RC_HD_NS, CLK_MHZ);
    localparam int unsigned C_DO    = ns_to_cyc(DATA_DLY_NS, CLK_MHZ);
    localparam int unsigned C_BR    = ns_to_cyc(RELQ_NS, CLK_MHZ);
    localparam int unsigned C_ACQ   = ns_to_cyc(ACQ_NS, CLK_MHZ);
    localparam int unsigned C_WAKE  = WAKE_US * CLK_MHZ;
    localparam int unsigned C_PER   = umax(ns_to_cyc(PERIOD_NS, CLK_MHZ), 1);
    localparam int unsigned C_LOW   = umax(umax(C_HD, C_CSL), 1);
    localparam int unsigned C_GUARD = umax(umax(C_SU0, C_CSH), 1);
    localparam int unsigned C_ACQR  = umax((C_ACQ > C_LOW) ? (C_ACQ - C_LOW) : 0, C_GUARD);
    localparam int unsigned C_F3    = umax(umax(C_DO, C_CSL), umax(C_HD, 1));
    localparam int unsigned C_REL   = umax(umax(C_BR, C_CSH), 1);
    localparam int unsigned C_TMO   = umax(ns_to_cyc(EOC_TMO_NS, CLK_MHZ), C_GUARD + 1);
    localparam int unsigned C_TOP   = umax(C_ACQR + C_WAKE, umax(C_TMO, C_PER));
    localparam int unsigned CW      = $clog2(C_TOP + 1) + 1;

    logic    per_due;
    logic    kick;
    logic    cap;
    logic    go;
    logic [DW-1:0] cap_word;
    seq_st_e fsm_st;

    assign go = run_en && per_due && !smp_valid;

    seq_period_gen #(
        .CW    (CW),
        .C_PER (C_PER)
    ) u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (kick),
        .due     (per_due)
    );

    seq_strobe_fsm #(
        .DW        (DW),
        .CW        (CW),
        .SYNC      (SYNC),
        .C_SU      (C_SU0),
        .C_LOW     (C_LOW),
        .C_ACQ_REM (C_ACQR),
        .C_WAKE    (C_WAKE),
        .C_GUARD   (C_GUARD),
        .C_F3      (C_F3),
        .C_REL     (C_REL),
        .C_TMO     (C_TMO)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .mode_sd  (pwr_down_sel),
        .done_n   (cvt_done_n),
        .bus      (cvt_bus),
        .sel_n    (cvt_sel_n),
        .rdsel    (cvt_rdsel),
        .cap      (cap),
        .cap_data (cap_word),
        .tmo      (conv_timeout),
        .kick     (kick),
        .st       (fsm_st)
    );

    seq_out_hold #(
        .DW (DW)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .cap_data (cap_word),
        .o_valid  (smp_valid),
        .o_ready  (smp_ready),
        .o_data   (smp_data)
    );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int unsigned DW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_n,
    input logic          rdsel,
    input logic          done_n,
    input logic          tmo,
    input logic          o_valid,
    input logic          o_ready,
    input logic [DW-1:0] o_data,
    input seq_st_e       st
);
    assert_first_fall_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sel_n) && st == ST_F1) |-> !rdsel);

    assert_read_phase_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_F3) |-> rdsel);

    assert_read_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sel_n) && st == ST_F3) |-> !done_n);

    assert_select_moves_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdsel) |-> sel_n);

    assert_timeout_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> (sel_n && st == ST_REL));

    assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));

    assert_no_start_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && st == ST_IDLE) |=> (st == ST_IDLE));
endmodule

bind adc_strobe_seq adc_seq_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n   (cvt_sel_n),
    .rdsel   (cvt_rdsel),
    .done_n  (cvt_done_n),
    .tmo     (conv_timeout),
    .o_valid (smp_valid),
    .o_ready (smp_ready),
    .o_data  (smp_data),
    .st      (fsm_st)
);

// File: tb/sim_adc_strobe_seq.sv
`timescale 1ns/1ps
module sim_adc_strobe_seq;
    localparam int DW       = 14;
    localparam int WAKE_US  = 4;
    localparam int PER_NS   = 4000;
    localparam int TMO_NS   = 8000;
    // expected minimums in 4 ns cycles, from the requirement values
    localparam int ACQ_CYC  = 500;
    localparam int WAKE_CYC = 1000;
    localparam int PER_CYC  = 1000;
    localparam int TMO_CYC  = 2000;
    localparam int SU_CYC   = 15;
    localparam int HD_CYC   = 10;
    localparam int CSW_CYC  = 10;
    localparam int BR_CYC   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic pwr_down_sel = 1'b0;
    logic cvt_sel_n, cvt_rdsel;
    logic cvt_done_n = 1'b1;
    logic [DW-1:0] cvt_bus = '0;
    logic smp_valid, smp_ready;
    logic [DW-1:0] smp_data;
    logic conv_timeout;

    always #2 clk = ~clk;

    adc_strobe_seq #(
        .DW(DW), .WAKE_US(WAKE_US), .EOC_TMO_NS(TMO_NS), .PERIOD_NS(PER_NS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwr_down_sel(pwr_down_sel),
        .cvt_sel_n(cvt_sel_n), .cvt_rdsel(cvt_rdsel), .cvt_done_n(cvt_done_n),
        .cvt_bus(cvt_bus), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_data(smp_data), .conv_timeout(conv_timeout)
    );

    int n_chk = 0, n_fail = 0;
    int unsigned cyc = 0;
    bit armed = 0, finished = 0;
    int phase = 0;
    int unsigned t_f1 = 0, t_f2 = 0, t_fall = 0, t_rise = 0, t_rc = 0, t_rel = 0;
    bit have_f1 = 0, have_rel = 0;
    int f1_cnt = 0, tmo_cnt = 0, n_pop = 0, k_word = 0;
    bit exp_mode = 0, no_eoc = 0;
    int conv_len = 1175;
    bit conv_req = 0, rd_req = 0;
    logic [DW-1:0] rd_val = '0;
    logic [DW-1:0] exp_q[$];
    bit rdy = 1'b1;
    assign smp_ready = rdy;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] next_word(input int k);
        case (k)
            0: return 14'h0000;
            1: return 14'h3FFF;
            2: return 14'h2000;
            3: return 14'h1FFF;
            default: return 14'((k * 2417 + 913) & 16'h3FFF);
        endcase
    endfunction

    // behavioural converter responder
    always @(negedge cvt_sel_n) begin
        if (armed) begin
            chk(cyc - t_rc >= SU_CYC, "R6 select setup", int'(cyc - t_rc), SU_CYC);
            chk(cyc - t_rise >= CSW_CYC, "R6 chip-select high width", int'(cyc - t_rise), CSW_CYC);
            t_fall = cyc;
            case (phase)
                0: begin
                    chk(cvt_rdsel == 1'b0, "R1 first fall select", int'(cvt_rdsel), 0);
                    chk(smp_valid == 1'b0, "R9 no start while word pending", int'(smp_valid), 0);
                    if (have_rel) chk(cyc - t_rel >= BR_CYC, "R7 relinquish gap", int'(cyc - t_rel), BR_CYC);
                    if (have_f1) chk(cyc - t_f1 >= PER_CYC, "R7 sample period", int'(cyc - t_f1), PER_CYC);
                    t_f1 = cyc; have_f1 = 1; f1_cnt++; phase = 1;
                end
                1: begin
                    chk(cvt_rdsel == exp_mode, "R2 second fall select", int'(cvt_rdsel), int'(exp_mode));
                    if (exp_mode)
                        chk(cyc - t_f1 >= ACQ_CYC + WAKE_CYC, "R4 wake-up stretch", int'(cyc - t_f1), ACQ_CYC + WAKE_CYC);
                    else
                        chk(cyc - t_f1 >= ACQ_CYC, "R3 acquisition length", int'(cyc - t_f1), ACQ_CYC);
                    t_f2 = cyc; phase = 2; conv_req = 1;
                end
                2: begin
                    chk(cvt_rdsel == 1'b1, "R1 third fall select", int'(cvt_rdsel), 1);
                    chk(cvt_done_n == 1'b0, "R5 read only after completion", int'(cvt_done_n), 0);
                    rd_val = next_word(k_word); k_word++;
                    exp_q.push_back(rd_val);
                    rd_req = 1; phase = 3;
                end
                default: chk(1'b0, "R1 extra fall", phase, 0);
            endcase
        end
    end

    always @(posedge cvt_sel_n) begin
        if (armed) begin
            chk(cyc - t_fall >= CSW_CYC, "R6 chip-select low width", int'(cyc - t_fall), CSW_CYC);
            t_rise = cyc;
            if (phase == 3) begin
                cvt_done_n = 1'b1; cvt_bus = '0; t_rel = cyc; have_rel = 1; phase = 0;
            end
        end
    end

    always @(cvt_rdsel) begin
        if (armed) begin
            chk(cyc - t_fall >= HD_CYC, "R6 select hold", int'(cyc - t_fall), HD_CYC);
            chk(cvt_sel_n == 1'b1, "R6 select moves while deselected", int'(cvt_sel_n), 1);
            t_rc = cyc;
        end
    end

    initial forever begin
        wait (conv_req);
        conv_req = 0;
        if (!no_eoc) begin
            repeat (conv_len) @(negedge clk);
            cvt_done_n = 1'b0;
        end
    end

    initial forever begin
        wait (rd_req);
        rd_req = 0;
        cvt_bus = ~rd_val;
        repeat (7) @(negedge clk);
        cvt_bus = rd_val;
    end

    // scoreboard monitor
    logic pv = 0, pr = 0;
    logic [DW-1:0] pd = '0;
    always @(negedge clk) begin
        if (armed) begin
            if (pv && !pr) begin
                chk(smp_valid && smp_data == pd, "R9 held word", int'(smp_data), int'(pd));
            end
            if (smp_valid && smp_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected word", int'(smp_data), -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(smp_data == e, "R5 captured word", int'(smp_data), int'(e));
                end
                n_pop++;
            end
            if (conv_timeout) begin
                tmo_cnt++;
                chk(cyc - t_f2 >= TMO_CYC && cyc - t_f2 <= TMO_CYC + 20, "R8 timeout moment",
                    int'(cyc - t_f2), TMO_CYC);
                chk(cvt_sel_n == 1'b1, "R8 deselected on timeout", int'(cvt_sel_n), 1);
                phase = 0;
            end
            pv = smp_valid; pr = smp_ready; pd = smp_data;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wait_items(input int k);
        int target;
        target = n_pop + k;
        while (n_pop < target) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", int'(cyc), 0);
        summary();
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        chk(cvt_sel_n == 1'b1, "R10 reset chip-select", int'(cvt_sel_n), 1);
        chk(cvt_rdsel == 1'b0, "R10 reset select line", int'(cvt_rdsel), 0);
        chk(smp_valid == 1'b0, "R10 reset valid", int'(smp_valid), 0);
        chk(conv_timeout == 1'b0, "R10 reset timeout", int'(conv_timeout), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        armed = 1;
        // R11: held off
        repeat (300) @(negedge clk);
        chk(f1_cnt == 0 && cvt_sel_n, "R11 idle while run low", f1_cnt, 0);
        // keep-alive, long conversions
        exp_mode = 0; pwr_down_sel = 0; run_en = 1;
        wait_items(4);
        // short conversions
        conv_len = 30;
        wait_items(2);
        // switch to low-power while drained
        run_en = 0;
        repeat (3000) @(negedge clk);
        snap = f1_cnt;
        repeat (2000) @(negedge clk);
        chk(f1_cnt == snap && cvt_sel_n, "R11 no sample with run low", f1_cnt, snap);
        exp_mode = 1; pwr_down_sel = 1; conv_len = 1175; run_en = 1;
        wait_items(3);
        // output stall
        rdy = 1'b0;
        repeat (4000) @(negedge clk);
        snap = f1_cnt;
        chk(smp_valid == 1'b1, "R9 word pending during stall", int'(smp_valid), 1);
        repeat (2000) @(negedge clk);
        chk(f1_cnt == snap, "R9 no new sample during stall", f1_cnt, snap);
        rdy = 1'b1;
        wait_items(2);
        // timeout
        exp_mode = 1;
        no_eoc = 1;
        snap = tmo_cnt;
        while (tmo_cnt == snap) @(negedge clk);
        no_eoc = 0;
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R8 no word after abandon", exp_q.size(), 0);
        chk(smp_valid == 1'b0, "R8 output empty after abandon", int'(smp_valid), 0);
        wait_items(2);
        chk(tmo_cnt == snap + 1, "R8 single timeout pulse", tmo_cnt, snap + 1);
        run_en = 0;
        repeat (3000) @(negedge clk);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule